// File: doc/BRIEF.md
# Regulator Undervoltage Fault Responder

This block supervises fourteen supply rails, four buck converters and ten LDO regulators. Each rail's undervoltage comparator flag has to stay high for a fixed run of clock cycles before it counts as a fault. The run length guards against brief load surges. Once a fault is confirmed, it always latches a sticky per-rail status bit and the shared undervoltage interrupt. A 2-bit code for each rail then chooses the extra response: nothing more, a one-cycle strobe that tells the register file to turn that rail off, or a one-cycle request to reset the whole device. A rail whose enable bit is low cannot raise a fault.

The block also handles reporting for the first two buck converters. An overvoltage flag latches a sticky status bit and raises no interrupt. A high-current indication, when enabled for that converter, compares a measured current code against a programmable threshold. It latches its own sticky status and a separate high-current interrupt. These two paths do not depend on the undervoltage action codes. Every sticky bit is cleared by a write-one-to-clear pulse from the register file.

Top module: `uvr_fault_resp`

## Requirements
- R1: Rail index i maps to bit i of every per-rail vector: bits 0 to 3 are the buck converters and bits 4 to 13 are the LDO regulators. A fault on one rail affects only that rail's bit.
- R2: A fault is confirmed at the rising edge where `uv_raw[i]` and `ch_ena[i]` have both been sampled high on 16 consecutive edges. Any edge that samples either one low restarts the count.
- R3: While `ch_ena[i]` is low, rail i never confirms a fault, however long `uv_raw[i]` stays high.
- R4: Every confirmed fault sets `uv_sts[i]` and `uv_irq` at the confirming edge, whatever its action code.
- R5: The action code is `act_cfg[2i+1:2i]`. 2'b00 means ignore. 2'b01 drives `ena_clr[i]` high for the one cycle after the confirming edge, so that the register file clears that rail's enable and its on-status. 2'b10 drives `sys_rst_req` high for that one cycle. 2'b11 behaves as 2'b00.
- R6: A fault held without a break produces exactly one strobe or reset request. A new one needs the flag to drop and qualify again.
- R7: All sticky bits reset to 0. Each one is cleared by a high clear input at an edge. A set and a clear at the same edge leave the bit set.
- R8: `ov_raw[j]` sampled high at an edge sets the sticky `ov_sts[j]` (j = 0, 1). It never raises any interrupt.
- R9: With `hc_ena[j]` high and the measured code strictly greater than the threshold code at an edge, `hc_sts[j]` and `hc_irq` set at that edge. An equal or lower code, or a low enable, sets nothing.
- R10: The undervoltage action codes have no effect on overvoltage or high-current outputs, and those inputs never drive `uv_irq`, `uv_sts`, `ena_clr` or `sys_rst_req`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| uv_raw | input | 14 | Raw undervoltage comparator flags, one per rail |
| ch_ena | input | 14 | Rail enable bits from the register file |
| act_cfg | input | 28 | 2-bit fault action code per rail |
| uv_sts_clr | input | 14 | Write-one-to-clear pulses for undervoltage status |
| uv_irq_clr | input | 1 | Clear pulse for the undervoltage interrupt |
| ov_raw | input | 2 | Overvoltage flags for bucks 1 and 2 |
| ov_sts_clr | input | 2 | Clear pulses for overvoltage status |
| hc_ena | input | 2 | High-current indication enables |
| hc_meas | input | 16 | Measured current codes, 8 bits per converter |
| hc_thr | input | 16 | High-current threshold codes, 8 bits per converter |
| hc_sts_clr | input | 2 | Clear pulses for high-current status |
| hc_irq_clr | input | 1 | Clear pulse for the high-current interrupt |
| uv_sts | output | 14 | Sticky undervoltage status per rail |
| uv_irq | output | 1 | Sticky undervoltage interrupt |
| ena_clr | output | 14 | One-cycle per-rail enable-clear strobes |
| sys_rst_req | output | 1 | One-cycle device reset request |
| ov_sts | output | 2 | Sticky overvoltage status |
| hc_sts | output | 2 | Sticky high-current status |
| hc_irq | output | 1 | Sticky high-current interrupt |

## Verification
The assertions check several properties on every cycle: no status bit rises before a full 16-cycle qualified run, a disabled rail never latches, and sticky bits hold until cleared. They also check that every strobe or reset request carries the interrupt, that strobes last one cycle and match the action code of the cycle before, and that the undervoltage interrupt rises only with undervoltage status present. Only the bench scenarios can show the exact confirming edge for every rail and action code, the restart after a one-cycle dropout, and set-over-clear priority. The same holds for threshold comparison at the equal and adjacent codes, and for the absence of effects between the overvoltage, high-current and undervoltage paths.

// File: rtl/uvr_pkg.sv
package uvr_pkg;

    localparam int unsigned BUCK_N    = 4;
    localparam int unsigned LDO_N     = 10;
    localparam int unsigned MON_N     = 2;
    localparam int unsigned PERSIST_N = 16;
    localparam int unsigned CUR_W     = 8;

    typedef enum logic [1:0] {
        ACT_IGNORE  = 2'b00,
        ACT_CH_OFF  = 2'b01,
        ACT_SYS_RST = 2'b10,
        ACT_RSVD    = 2'b11
    } uv_act_e;

    typedef struct packed {
        logic ch_off;
        logic sys_rst;
    } uv_resp_t;

    typedef struct packed {
        logic ov_set;
        logic hc_set;
    } mon_evt_t;

    function automatic uv_resp_t resp_of(input logic [1:0] code);
        uv_resp_t r;
        r = '0;
        case (uv_act_e'(code))
            ACT_CH_OFF:  r.ch_off  = 1'b1;
            ACT_SYS_RST: r.sys_rst = 1'b1;
            default:     r = '0;
        endcase
        return r;
    endfunction

    function automatic logic sticky_next(input logic cur, input logic set, input logic clr);
        return set | (cur & ~clr);
    endfunction

endpackage

// File: rtl/uvr_persist.sv
module uvr_persist #(
    parameter int unsigned PERSIST_CYC = uvr_pkg::PERSIST_N
) (
    input  logic clk,
    input  logic rst,
    input  logic raw,
    input  logic ena,
    output logic fault_evt
);
    localparam int unsigned CNT_W = $clog2(PERSIST_CYC + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(PERSIST_CYC - 1);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(PERSIST_CYC);

    logic [CNT_W-1:0] cnt_q;
    logic             qual;

    assign qual      = raw & ena;
    assign fault_evt = qual && (cnt_q == LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (!qual) begin
            cnt_q <= '0;
        end else if (cnt_q != FULL) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/uvr_uv_resp.sv
module uvr_uv_resp #(
    parameter int unsigned NUM_CH = uvr_pkg::BUCK_N + uvr_pkg::LDO_N
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NUM_CH-1:0]   fault_evt,
    input  logic [2*NUM_CH-1:0] act_cfg,
    input  logic [NUM_CH-1:0]   sts_clr,
    input  logic                irq_clr,
    output logic [NUM_CH-1:0]   uv_sts,
    output logic                uv_irq,
    output logic [NUM_CH-1:0]   ena_clr,
    output logic                sys_rst_req
);
    import uvr_pkg::*;

    uv_resp_t [NUM_CH-1:0] resp;
    logic     [NUM_CH-1:0] off_hit;
    logic     [NUM_CH-1:0] rst_hit;
    logic     [NUM_CH-1:0] sts_d;

    logic [NUM_CH-1:0] sts_q;
    logic [NUM_CH-1:0] clr_q;
    logic              irq_q;
    logic              rst_q;

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        assign resp[i]    = resp_of(act_cfg[2*i +: 2]);
        assign off_hit[i] = fault_evt[i] & resp[i].ch_off;
        assign rst_hit[i] = fault_evt[i] & resp[i].sys_rst;
        assign sts_d[i]   = sticky_next(sts_q[i], fault_evt[i], sts_clr[i]);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sts_q <= '0;
            clr_q <= '0;
            irq_q <= 1'b0;
            rst_q <= 1'b0;
        end else begin
            sts_q <= sts_d;
            clr_q <= off_hit;
            irq_q <= sticky_next(irq_q, |fault_evt, irq_clr);
            rst_q <= |rst_hit;
        end
    end

    assign uv_sts      = sts_q;
    assign uv_irq      = irq_q;
    assign ena_clr     = clr_q;
    assign sys_rst_req = rst_q;
endmodule

// File: rtl/uvr_mon.sv
module uvr_mon #(
    parameter int unsigned NUM_MON = uvr_pkg::MON_N,
    parameter int unsigned HC_W    = uvr_pkg::CUR_W
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [NUM_MON-1:0]      ov_raw,
    input  logic [NUM_MON-1:0]      ov_sts_clr,
    input  logic [NUM_MON-1:0]      hc_ena,
    input  logic [NUM_MON*HC_W-1:0] hc_meas,
    input  logic [NUM_MON*HC_W-1:0] hc_thr,
    input  logic [NUM_MON-1:0]      hc_sts_clr,
    input  logic                    hc_irq_clr,
    output logic [NUM_MON-1:0]      ov_sts,
    output logic [NUM_MON-1:0]      hc_sts,
    output logic                    hc_irq
);
    import uvr_pkg::*;

    mon_evt_t [NUM_MON-1:0] evt;
    logic     [NUM_MON-1:0] hc_any;
    logic     [NUM_MON-1:0] ov_q;
    logic     [NUM_MON-1:0] hc_q;
    logic                   irq_q;

    for (genvar j = 0; j < NUM_MON; j++) begin : g_mon
        assign evt[j].ov_set = ov_raw[j];
        assign evt[j].hc_set = hc_ena[j] && (hc_meas[j*HC_W +: HC_W] > hc_thr[j*HC_W +: HC_W]);
        assign hc_any[j]     = evt[j].hc_set;

        always_ff @(posedge clk) begin
            if (rst) begin
                ov_q[j] <= 1'b0;
                hc_q[j] <= 1'b0;
            end else begin
                ov_q[j] <= sticky_next(ov_q[j], evt[j].ov_set, ov_sts_clr[j]);
                hc_q[j] <= sticky_next(hc_q[j], evt[j].hc_set, hc_sts_clr[j]);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) irq_q <= 1'b0;
        else     irq_q <= sticky_next(irq_q, |hc_any, hc_irq_clr);
    end

    assign ov_sts = ov_q;
    assign hc_sts = hc_q;
    assign hc_irq = irq_q;
endmodule

// File: rtl/uvr_fault_resp.sv
module uvr_fault_resp #(
    parameter int unsigned NUM_BUCK    = uvr_pkg::BUCK_N,
    parameter int unsigned NUM_LDO     = uvr_pkg::LDO_N,
    parameter int unsigned NUM_MON     = uvr_pkg::MON_N,
    parameter int unsigned PERSIST_CYC = uvr_pkg::PERSIST_N,
    parameter int unsigned HC_W        = uvr_pkg::CUR_W
) (
    input  logic                                clk,
    input  logic                                rst,
    input  logic [NUM_BUCK+NUM_LDO-1:0]         uv_raw,
    input  logic [NUM_BUCK+NUM_LDO-1:0]         ch_ena,
    input  logic [2*(NUM_BUCK+NUM_LDO)-1:0]     act_cfg,
    input  logic [NUM_BUCK+NUM_LDO-1:0]         uv_sts_clr,
    input  logic                                uv_irq_clr,
    input  logic [NUM_MON-1:0]                  ov_raw,
    input  logic [NUM_MON-1:0]                  ov_sts_clr,
    input  logic [NUM_MON-1:0]                  hc_ena,
    input  logic [NUM_MON*HC_W-1:0]             hc_meas,
    input  logic [NUM_MON*HC_W-1:0]             hc_thr,
    input  logic [NUM_MON-1:0]                  hc_sts_clr,
    input  logic                                hc_irq_clr,
    output logic [NUM_BUCK+NUM_LDO-1:0]         uv_sts,
    output logic                                uv_irq,
    output logic [NUM_BUCK+NUM_LDO-1:0]         ena_clr,
    output logic                                sys_rst_req,
    output logic [NUM_MON-1:0]                  ov_sts,
    output logic [NUM_MON-1:0]                  hc_sts,
    output logic                                hc_irq
);
    localparam int unsigned NUM_CH = NUM_BUCK + NUM_LDO;

    logic [NUM_CH-1:0] fault_evt;

    for (genvar i = 0; i < NUM_CH; i++) begin : g_persist
        uvr_persist #(.PERSIST_CYC(PERSIST_CYC)) u_persist (
            .clk       (clk),
            .rst       (rst),
            .raw       (uv_raw[i]),
            .ena       (ch_ena[i]),
            .fault_evt (fault_evt[i])
        );
    end

    uvr_uv_resp #(.NUM_CH(NUM_CH)) u_resp (
        .clk         (clk),
        .rst         (rst),
        .fault_evt   (fault_evt),
        .act_cfg     (act_cfg),
        .sts_clr     (uv_sts_clr),
        .irq_clr     (uv_irq_clr),
        .uv_sts      (uv_sts),
        .uv_irq      (uv_irq),
        .ena_clr     (ena_clr),
        .sys_rst_req (sys_rst_req)
    );

    uvr_mon #(.NUM_MON(NUM_MON), .HC_W(HC_W)) u_mon (
        .clk        (clk),
        .rst        (rst),
        .ov_raw     (ov_raw),
        .ov_sts_clr (ov_sts_clr),
        .hc_ena     (hc_ena),
        .hc_meas    (hc_meas),
        .hc_thr     (hc_thr),
        .hc_sts_clr (hc_sts_clr),
        .hc_irq_clr (hc_irq_clr),
        .ov_sts     (ov_sts),
        .hc_sts     (hc_sts),
        .hc_irq     (hc_irq)
    );
endmodule

// File: rtl/uvr_fault_resp_chk.sv
module uvr_fault_resp_chk #(
    parameter int unsigned NUM_CH      = 14,
    parameter int unsigned NUM_MON     = 2,
    parameter int unsigned PERSIST_CYC = 16
) (
    input logic                clk,
    input logic                rst,
    input logic [NUM_CH-1:0]   uv_raw,
    input logic [NUM_CH-1:0]   ch_ena,
    input logic [2*NUM_CH-1:0] act_cfg,
    input logic [NUM_CH-1:0]   uv_sts_clr,
    input logic [NUM_CH-1:0]   uv_sts,
    input logic                uv_irq,
    input logic [NUM_CH-1:0]   ena_clr,
    input logic                sys_rst_req,
    input logic [NUM_MON-1:0]  ov_raw,
    input logic [NUM_MON-1:0]  ov_sts,
    input logic [NUM_MON-1:0]  ov_sts_clr,
    input logic [NUM_MON-1:0]  hc_sts,
    input logic                hc_irq
);
    localparam int unsigned RUN_W = $clog2(PERSIST_CYC + 1);
    localparam logic [RUN_W-1:0] RUN_FULL = RUN_W'(PERSIST_CYC);

    for (genvar i = 0; i < NUM_CH; i++) begin : g_uv
        logic [RUN_W-1:0] run_q;

        always_ff @(posedge clk) begin
            if (rst || !(uv_raw[i] && ch_ena[i])) run_q <= '0;
            else if (run_q != RUN_FULL)           run_q <= run_q + 1'b1;
        end

        AST_UV_NEEDS_PERSIST: assert property (@(posedge clk) disable iff (rst)
            $rose(uv_sts[i]) |-> (run_q == RUN_FULL)); // R2

        AST_MASK_BLOCKS_FAULT: assert property (@(posedge clk) disable iff (rst)
            !ch_ena[i] |=> !$rose(uv_sts[i])); // R3

        AST_UV_STS_STICKY: assert property (@(posedge clk) disable iff (rst)
            (uv_sts[i] && !uv_sts_clr[i]) |=> uv_sts[i]); // R7

        AST_STROBE_HAS_IRQ: assert property (@(posedge clk) disable iff (rst)
            ena_clr[i] |-> (uv_irq && uv_sts[i])); // R4

        AST_STROBE_ACTION: assert property (@(posedge clk) disable iff (rst)
            ena_clr[i] |-> ($past(act_cfg[2*i +: 2]) == 2'b01)); // R5

        AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (rst)
            ena_clr[i] |=> !ena_clr[i]); // R6
    end

    AST_SYSRST_HAS_IRQ: assert property (@(posedge clk) disable iff (rst)
        sys_rst_req |-> uv_irq); // R4

    AST_SYSRST_SINGLE: assert property (@(posedge clk) disable iff (rst)
        sys_rst_req |=> !sys_rst_req); // R6

    AST_UV_IRQ_SOURCE: assert property (@(posedge clk) disable iff (rst)
        $rose(uv_irq) |-> (uv_sts != '0)); // R10

    for (genvar j = 0; j < NUM_MON; j++) begin : g_mon
        AST_OV_CAPTURE: assert property (@(posedge clk) disable iff (rst)
            ov_raw[j] |=> ov_sts[j]); // R8

        AST_OV_STICKY: assert property (@(posedge clk) disable iff (rst)
            (ov_sts[j] && !ov_sts_clr[j]) |=> ov_sts[j]); // R8

        AST_HC_RAISES_IRQ: assert property (@(posedge clk) disable iff (rst)
            $rose(hc_sts[j]) |-> hc_irq); // R9
    end
endmodule

bind uvr_fault_resp uvr_fault_resp_chk #(
    .NUM_CH      (NUM_BUCK + NUM_LDO),
    .NUM_MON     (NUM_MON),
    .PERSIST_CYC (PERSIST_CYC)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .uv_raw      (uv_raw),
    .ch_ena      (ch_ena),
    .act_cfg     (act_cfg),
    .uv_sts_clr  (uv_sts_clr),
    .uv_sts      (uv_sts),
    .uv_irq      (uv_irq),
    .ena_clr     (ena_clr),
    .sys_rst_req (sys_rst_req),
    .ov_raw      (ov_raw),
    .ov_sts      (ov_sts),
    .ov_sts_clr  (ov_sts_clr),
    .hc_sts      (hc_sts),
    .hc_irq      (hc_irq)
);

// File: tb/sim_uvr_fault_resp.sv
module sim_uvr_fault_resp;
    localparam int CH  = 14;
    localparam int MON = 2;
    localparam int PER = 16;
    localparam int HW  = 8;

    logic              clk = 1'b0;
    logic              rst;
    logic [CH-1:0]     uv_raw, ch_ena, uv_sts_clr, uv_sts, ena_clr;
    logic [2*CH-1:0]   act_cfg;
    logic              uv_irq_clr, uv_irq, sys_rst_req, hc_irq_clr, hc_irq;
    logic [MON-1:0]    ov_raw, ov_sts_clr, hc_ena, hc_sts_clr, ov_sts, hc_sts;
    logic [MON*HW-1:0] hc_meas, hc_thr;

    int n_chk  = 0;
    int n_fail = 0;

    always #2.5ns clk = ~clk;

    uvr_fault_resp u0 (
        .clk(clk), .rst(rst), .uv_raw(uv_raw), .ch_ena(ch_ena), .act_cfg(act_cfg),
        .uv_sts_clr(uv_sts_clr), .uv_irq_clr(uv_irq_clr), .ov_raw(ov_raw),
        .ov_sts_clr(ov_sts_clr), .hc_ena(hc_ena), .hc_meas(hc_meas), .hc_thr(hc_thr),
        .hc_sts_clr(hc_sts_clr), .hc_irq_clr(hc_irq_clr), .uv_sts(uv_sts),
        .uv_irq(uv_irq), .ena_clr(ena_clr), .sys_rst_req(sys_rst_req),
        .ov_sts(ov_sts), .hc_sts(hc_sts), .hc_irq(hc_irq)
    );

    task automatic step(input int n);
        repeat (n) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    task automatic chk(input string req, input string what, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic clear_all();
        uv_raw = '0; ov_raw = '0; hc_ena = '0; hc_meas = '0;
        uv_sts_clr = '1; uv_irq_clr = 1'b1; ov_sts_clr = '1; hc_sts_clr = '1; hc_irq_clr = 1'b1;
        step(1);
        uv_sts_clr = '0; uv_irq_clr = 1'b0; ov_sts_clr = '0; hc_sts_clr = '0; hc_irq_clr = 1'b0;
        step(1);
    endtask

    initial begin
        #(5ns * 150000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        rst = 1'b1;
        uv_raw = '0; ch_ena = '1; act_cfg = '0; uv_sts_clr = '0; uv_irq_clr = 1'b0;
        ov_raw = '0; ov_sts_clr = '0; hc_ena = '0; hc_meas = '0; hc_thr = '0;
        hc_sts_clr = '0; hc_irq_clr = 1'b0;
        step(3);
        rst = 1'b0;
        step(1);
        // R7 reset state
        chk("R7", "reset uv_sts", uv_sts, 0);
        chk("R7", "reset uv_irq", uv_irq, 0);
        chk("R7", "reset ena_clr", ena_clr, 0);
        chk("R7", "reset sys_rst_req", sys_rst_req, 0);
        chk("R7", "reset ov/hc", {ov_sts, hc_sts, hc_irq}, 0);

        // R1 R2 R4 R5 R6: every rail with every action code
        for (int c = 0; c < CH; c++) begin
            for (int a = 0; a < 4; a++) begin
                longint one;
                one = longint'(1) << c;
                act_cfg = '0;
                act_cfg[2*c +: 2] = 2'(a);
                ch_ena = '1;
                uv_raw = CH'(one);
                step(PER - 1);
                chk("R2", "uv_sts before full run", uv_sts, 0);
                chk("R2", "uv_irq before full run", uv_irq, 0);
                step(1);
                chk("R1", "uv_sts rail bit", uv_sts, one);
                chk("R4", "uv_irq on fault", uv_irq, 1);
                chk("R5", "ena_clr strobe", ena_clr, (a == 1) ? one : 0);
                chk("R5", "sys_rst_req", sys_rst_req, (a == 2) ? 1 : 0);
                step(1);
                chk("R6", "strobe width", {ena_clr, sys_rst_req}, 0);
                step(6);
                chk("R6", "no repeat while held", {ena_clr, sys_rst_req}, 0);
                clear_all();
                chk("R7", "cleared uv_sts/irq", {uv_sts, uv_irq}, 0);
            end
        end

        // R2 dropout restarts the count
        act_cfg = '0; act_cfg[2*5 +: 2] = 2'b01;
        uv_raw = CH'(1 << 5);
        step(10);
        uv_raw = '0;
        step(1);
        uv_raw = CH'(1 << 5);
        step(PER - 1);
        chk("R2", "restart after dropout", uv_sts, 0);
        step(1);
        chk("R2", "fault after restart", uv_sts, 1 << 5);
        chk("R5", "strobe after restart", ena_clr, 1 << 5);
        clear_all();

        // R3 masked rail
        act_cfg = '0; act_cfg[2*7 +: 2] = 2'b01;
        ch_ena = ~CH'(1 << 7);
        uv_raw = CH'(1 << 7);
        step(40);
        chk("R3", "masked uv_sts", uv_sts, 0);
        chk("R3", "masked uv_irq", uv_irq, 0);
        chk("R3", "masked ena_clr", ena_clr, 0);
        ch_ena = '1;
        step(PER);
        chk("R3", "unmasked fault", uv_sts, 1 << 7);
        clear_all();

        // R7 set wins over a simultaneous clear
        act_cfg = '0;
        uv_raw = CH'(1 << 2);
        step(PER - 1);
        uv_sts_clr = CH'(1 << 2); uv_irq_clr = 1'b1;
        step(1);
        uv_sts_clr = '0; uv_irq_clr = 1'b0;
        chk("R7", "set wins uv_sts", uv_sts, 1 << 2);
        chk("R7", "set wins uv_irq", uv_irq, 1);
        clear_all();

        // R5 all rails together, disable action
        for (int c = 0; c < CH; c++) act_cfg[2*c +: 2] = 2'b01;
        uv_raw = '1;
        step(PER);
        chk("R5", "all strobes", ena_clr, (longint'(1) << CH) - 1);
        chk("R4", "all status", uv_sts, (longint'(1) << CH) - 1);
        clear_all();

        // R8 R10 overvoltage
        for (int c = 0; c < CH; c++) act_cfg[2*c +: 2] = 2'b10;
        ov_raw = 2'b10;
        step(1);
        ov_raw = '0;
        chk("R8", "ov_sts set", ov_sts, 2'b10);
        chk("R10", "ov no uv effect", {uv_irq, uv_sts, ena_clr, sys_rst_req}, 0);
        chk("R8", "ov no hc irq", {hc_irq, hc_sts}, 0);
        step(3);
        chk("R8", "ov_sts sticky", ov_sts, 2'b10);
        ov_sts_clr = 2'b10;
        step(1);
        ov_sts_clr = '0;
        chk("R8", "ov_sts cleared", ov_sts, 0);
        ov_raw = 2'b01;
        step(1);
        ov_raw = '0;
        chk("R8", "ov_sts rail 0", ov_sts, 2'b01);
        clear_all();

        // R9 R10 high current sweep
        for (int j = 0; j < MON; j++) begin
            for (int e = 0; e < 2; e++) begin
                for (int k = 0; k < 5; k++) begin
                    int m;
                    int t;
                    t = 100 + 20 * j;
                    case (k)
                        0: m = t - 1;
                        1: m = t;
                        2: m = t + 1;
                        3: m = 255;
                        default: m = 0;
                    endcase
                    hc_thr = '0;
                    hc_thr[j*HW +: HW] = HW'(t);
                    hc_meas = '0;
                    hc_meas[j*HW +: HW] = HW'(m);
                    hc_ena = '0;
                    hc_ena[j] = 1'(e);
                    step(1);
                    chk("R9", "hc_sts", hc_sts, (e == 1 && m > t) ? (1 << j) : 0);
                    chk("R9", "hc_irq", hc_irq, (e == 1 && m > t) ? 1 : 0);
                    chk("R10", "hc no uv effect", {uv_irq, sys_rst_req, ov_sts}, 0);
                    clear_all();
                end
            end
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule